// File: doc/BRIEF.md
# Interrupt Status and Enable Controller

This block gathers single-cycle event pulses from a storage-card host's command engine and data path into two 16-bit status registers: one for normal completion and readiness events, one for error conditions. Each event is latched only when its bit in the matching latch-mask register is set. Software clears latched bits by writing ones to them. A separate pair of signal-enable registers chooses which latched bits drive the single, registered, active-high interrupt line.

Bit 15 of the normal status register is not stored. It is a live summary of the error status register, so a single read of normal status shows whether any error is pending. A self-clearing software reset bit returns every status, mask and enable register to zero for a fixed number of cycles. Events and writes are ignored while that reset runs.

Top module: `irq_status_ctrl`

## Requirements
- R1: Normal status stores events at bit 0 command complete, 1 data complete, 2 block gap, 3 DMA complete, 4 write space available, 5 read data available, 8 card interrupt, 10 eight-word read available, 11 eight-word write available. The mask and enable registers of this group store only these bits (implemented mask 0x0D3F). Every other bit reads 0.
- R2: An event pulse sets its status bit at the next clock edge only when the matching latch-mask bit is 1. A masked event leaves status unchanged.
- R3: Bit 15 of normal status reads 1 exactly when any error status bit is 1. Writing to bit 15 has no effect.
- R4: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged.
- R5: Register word addresses are 0 normal status, 1 error status, 2 normal mask, 3 error mask, 4 normal enable, 5 error enable, 6 control. Only bits 15:0 of the 32-bit write data take effect.
- R6: An event and a write-one-to-clear on the same bit in the same cycle leave the bit set.
- R7: `irq` is registered. It is 1 one cycle after any status bit is 1 together with its enable bit, in either group, and it is 0 when no such pair exists.
- R8: Writing 1 to bit 8 of the control register starts a software reset. That bit reads 1 for 8 cycles and then reads 0. All status, mask and enable registers read 0 afterwards, and `irq` is 0.
- R9: Error status stores events at bit 0 command timeout, 1 command CRC, 2 command end bit, 3 command index, 4 data timeout, 5 data CRC, 6 data end bit, 8 auto-stop error, 9 command start, 10 transfer size, 11 response transmit bit, 12 CRC-status end bit, 13 CRC-status start bit, 14 CRC-status error (implemented mask 0x7F7F). Bits 7 and 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| norm_evt | input | 16 | Normal event pulses, one bit per status position |
| err_evt | input | 16 | Error event pulses, one bit per status position |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data; only bits 15:0 are used |
| reg_rdata | output | 16 | Read data of the addressed register (combinational) |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The assertions assume that event inputs are defined at every clock edge after reset and that a write strobe is paired with a valid address. They also assume that status is read through the normal and error groups, so a clear and a latch on the same bit are judged against the mask in force in that cycle. The stimulus changes every input only on the falling edge. It never changes a mask and sends a dependent event in the same cycle, so each expected value follows from a single register update. Events are also driven during a software reset, to show that they do not survive it.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [2:0] {
      A_NSTAT = 3'd0,
      A_ESTAT = 3'd1,
      A_NMASK = 3'd2,
      A_EMASK = 3'd3,
      A_NEN   = 3'd4,
      A_EEN   = 3'd5,
      A_CTRL  = 3'd6
   } reg_addr_e;

   localparam logic [15:0] NORM_IMPL = 16'h0D3F;
   localparam logic [15:0] ERR_IMPL  = 16'h7F7F;
   localparam int          SUM_BIT   = 15;
   localparam int          RST_BIT   = 8;
endpackage

// File: rtl/irq_grp.sv
module irq_grp #(
   parameter int          DW   = 16,
   parameter logic [DW-1:0] IMPL = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [DW-1:0] evt,
   input  logic          wr_stat,
   input  logic          wr_mask,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] stat,
   output logic [DW-1:0] mask,
   output logic [DW-1:0] en
);
   logic unused_bits;
   assign unused_bits = ^(wdata & ~IMPL) ^ ^(evt & ~IMPL);

   for (genvar b = 0; b < DW; b++) begin : g_bit
      if (IMPL[b]) begin : g_impl
         logic s_q, m_q, e_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_q <= 1'b0;
               m_q <= 1'b0;
               e_q <= 1'b0;
            end else if (clr) begin
               s_q <= 1'b0;
               m_q <= 1'b0;
               e_q <= 1'b0;
            end else begin
               // a latched event has priority over a same-cycle clear
               s_q <= (s_q & ~(wr_stat & wdata[b])) | (evt[b] & m_q);
               if (wr_mask) m_q <= wdata[b];
               if (wr_en)   e_q <= wdata[b];
            end
         end
         assign stat[b] = s_q;
         assign mask[b] = m_q;
         assign en[b]   = e_q;
      end else begin : g_tie
         assign stat[b] = 1'b0;
         assign mask[b] = 1'b0;
         assign en[b]   = 1'b0;
      end
   end
endmodule

// File: rtl/irq_swrst.sv
module irq_swrst #(
   parameter int CYC = 8,
   localparam int CW = $clog2(CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start)          cnt_q <= CW'(CYC);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
   import irq_pkg::*;
#(
   parameter int DW         = 16,
   parameter int BUS_W      = 32,
   parameter int RST_CYCLES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DW-1:0]    norm_evt,
   input  logic [DW-1:0]    err_evt,
   input  logic             reg_we,
   input  logic [2:0]       reg_addr,
   input  logic [BUS_W-1:0] reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   output logic             irq
);
   if (DW != 16) begin : g_bad_dw
      $error("irq_status_ctrl: DW must be 16");
   end
   if (BUS_W < DW) begin : g_bad_bus
      $error("irq_status_ctrl: BUS_W must be at least DW");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("irq_status_ctrl: RST_CYCLES must be at least 1");
   end

   localparam logic [DW-1:0] N_IMPL = DW'(NORM_IMPL);
   localparam logic [DW-1:0] E_IMPL = DW'(ERR_IMPL);

   reg_addr_e     addr;
   logic [DW-1:0] wd;
   logic [DW-1:0] nstat, nmask, nen, estat, emask, een;
   logic          rst_busy, rst_start, clr;
   logic          irq_q;

   assign addr = reg_addr_e'(reg_addr);
   assign wd   = reg_wdata[DW-1:0];

   if (BUS_W > DW) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^reg_wdata[BUS_W-1:DW];
   end

   assign rst_start = reg_we && addr == A_CTRL && wd[RST_BIT] && !rst_busy;
   assign clr       = rst_start | rst_busy;

   irq_swrst #(.CYC(RST_CYCLES)) u_rst (
      .clk(clk), .rst_n(rst_n), .start(rst_start), .busy(rst_busy)
   );

   irq_grp #(.DW(DW), .IMPL(N_IMPL)) u_norm (
      .clk(clk), .rst_n(rst_n), .clr(clr), .evt(norm_evt),
      .wr_stat(reg_we && addr == A_NSTAT),
      .wr_mask(reg_we && addr == A_NMASK),
      .wr_en  (reg_we && addr == A_NEN),
      .wdata(wd), .stat(nstat), .mask(nmask), .en(nen)
   );

   irq_grp #(.DW(DW), .IMPL(E_IMPL)) u_err (
      .clk(clk), .rst_n(rst_n), .clr(clr), .evt(err_evt),
      .wr_stat(reg_we && addr == A_ESTAT),
      .wr_mask(reg_we && addr == A_EMASK),
      .wr_en  (reg_we && addr == A_EEN),
      .wdata(wd), .stat(estat), .mask(emask), .en(een)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   irq_q <= 1'b0;
      else if (clr) irq_q <= 1'b0;
      else          irq_q <= (|(nstat & nen)) | (|(estat & een));
   end
   assign irq = irq_q;

   always_comb begin
      reg_rdata = '0;
      unique case (addr)
         A_NSTAT: begin
            reg_rdata          = nstat;
            reg_rdata[SUM_BIT] = |estat;
         end
         A_ESTAT: reg_rdata = estat;
         A_NMASK: reg_rdata = nmask;
         A_EMASK: reg_rdata = emask;
         A_NEN:   reg_rdata = nen;
         A_EEN:   reg_rdata = een;
         A_CTRL:  reg_rdata[RST_BIT] = rst_busy;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        clr,
   input logic        busy,
   input logic        we,
   input logic [2:0]  addr,
   input logic [15:0] wd,
   input logic [15:0] nevt,
   input logic [15:0] nmask,
   input logic [15:0] nstat,
   input logic [15:0] nen,
   input logic [15:0] estat,
   input logic [15:0] emask,
   input logic [15:0] een,
   input logic        irq
);
   // R2 and R6: an unmasked event is set next cycle, even against a clear
   a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && (nevt & nmask) != 16'h0) |=>
         ((nstat & $past(nevt & nmask)) == $past(nevt & nmask)));

   // R4: written ones clear bits that saw no event
   a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == 3'd0 && !clr) |=>
         ((nstat & $past(wd & ~(nevt & nmask))) == 16'h0));

   // R2: with nothing latched and no unmasked event, status stays empty
   a_r2_masked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && nstat == 16'h0 && (nevt & nmask) == 16'h0) |=> (nstat == 16'h0));

   // R7: no enable in either group means no interrupt next cycle
   a_r7_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (nen == 16'h0 && een == 16'h0) |=> !irq);

   // R8: while the software reset runs every register is empty
   a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (nstat == 16'h0 && estat == 16'h0 && nmask == 16'h0 &&
                emask == 16'h0 && nen == 16'h0 && een == 16'h0 && !irq));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .busy(rst_busy),
   .we(reg_we), .addr(reg_addr), .wd(reg_wdata[15:0]),
   .nevt(norm_evt), .nmask(nmask), .nstat(nstat), .nen(nen),
   .estat(estat), .emask(emask), .een(een), .irq(irq)
);

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] norm_evt = '0, err_evt = '0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_status_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .norm_evt(norm_evt), .err_evt(err_evt),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   typedef struct packed {
      logic        we;
      logic [2:0]  waddr;
      logic [31:0] wdata;
      logic [15:0] nevt;
      logic [15:0] eevt;
      logic [2:0]  raddr;
      logic [15:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 3'd2, 32'h1234_FFFF, 16'h0, 16'h0, 3'd2, 16'h0D3F, 4'd1}, // R1 R5
      '{1'b1, 3'd3, 32'hFFFF_FFFF, 16'h0, 16'h0, 3'd3, 16'h7F7F, 4'd9}, // R9 R5
      '{1'b0, 3'd0, 32'h0,         16'h0001, 16'h0, 3'd0, 16'h0001, 4'd2}, // R2
      '{1'b0, 3'd0, 32'h0,         16'h0, 16'h0010, 3'd0, 16'h8001, 4'd3}, // R3
      '{1'b0, 3'd0, 32'h0,         16'h0, 16'h0, 3'd1, 16'h0010, 4'd9}, // R9
      '{1'b0, 3'd0, 32'h0,         16'h0, 16'h8080, 3'd1, 16'h0010, 4'd9}, // R9 unimplemented
      '{1'b1, 3'd0, 32'h0000_8000, 16'h0, 16'h0, 3'd0, 16'h8001, 4'd3}, // R3 write to summary
      '{1'b1, 3'd1, 32'h0000_0000, 16'h0, 16'h0, 3'd1, 16'h0010, 4'd4}, // R4 zeros keep
      '{1'b1, 3'd1, 32'h0000_0010, 16'h0, 16'h0, 3'd0, 16'h0001, 4'd4}, // R4 R3
      '{1'b1, 3'd0, 32'h0000_0001, 16'h0001, 16'h0, 3'd0, 16'h0001, 4'd6}, // R6
      '{1'b1, 3'd0, 32'hFFFF_0001, 16'h0, 16'h0, 3'd0, 16'h0000, 4'd4}, // R4
      '{1'b1, 3'd2, 32'h0000_0000, 16'h0, 16'h0, 3'd2, 16'h0000, 4'd5}, // R5
      '{1'b0, 3'd0, 32'h0,         16'hFFFF, 16'h0, 3'd0, 16'h0000, 4'd2}, // R2 masked
      '{1'b1, 3'd2, 32'h0000_0002, 16'h0, 16'h0, 3'd2, 16'h0002, 4'd5}, // R5
      '{1'b0, 3'd0, 32'h0,         16'h0003, 16'h0, 3'd0, 16'h0002, 4'd2}  // R2 partial mask
   };

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string what);
      reg_addr = a;
      #1;
      check(reg_rdata, exp, what);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8 reset state
      for (int a = 0; a < 7; a++) rd(3'(a), 16'h0, "R8 reset value");
      check({15'h0, irq}, 16'h0, "R7 irq after reset");

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         reg_we = VEC[i].we; reg_addr = VEC[i].waddr; reg_wdata = VEC[i].wdata;
         norm_evt = VEC[i].nevt; err_evt = VEC[i].eevt;
         @(negedge clk);
         reg_we = 1'b0; norm_evt = '0; err_evt = '0;
         rd(VEC[i].raddr, VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].req, i));
      end

      // R7 normal path: status 0x0002 pending, enable it
      wr(3'd4, 32'h0000_0002);
      check({15'h0, irq}, 16'h0, "R7 irq registered delay");
      @(negedge clk);
      check({15'h0, irq}, 16'h1, "R7 irq on normal");
      wr(3'd4, 32'h0);
      @(negedge clk);
      check({15'h0, irq}, 16'h0, "R7 irq off after disable");

      // R7 error path
      wr(3'd5, 32'h0000_0001);
      @(negedge clk);
      err_evt = 16'h0001;
      @(negedge clk);
      err_evt = '0;
      check({15'h0, irq}, 16'h0, "R7 irq one cycle after error latch");
      rd(3'd0, 16'h8002, "R3 summary with normal bit");
      @(negedge clk);
      check({15'h0, irq}, 16'h1, "R7 irq on error");

      // R8 software reset
      wr(3'd6, 32'h0000_0100);
      rd(3'd6, 16'h0100, "R8 reset bit busy");
      for (int k = 0; k < 7; k++) begin
         @(negedge clk);
         norm_evt = 16'hFFFF; err_evt = 16'hFFFF;
      end
      norm_evt = '0; err_evt = '0;
      rd(3'd6, 16'h0100, "R8 busy in last cycle");
      @(negedge clk);
      rd(3'd6, 16'h0000, "R8 reset bit self-clears");
      for (int a = 0; a < 6; a++) rd(3'(a), 16'h0, "R8 register cleared");
      check({15'h0, irq}, 16'h0, "R8 irq cleared");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule